// File: doc/BRIEF.md
# Low Power Stop and Wakeup Controller

This block puts a processing subsystem into a low power stop state when it receives a stop command, and brings it back out. When it accepts the command, it stores two things for the whole stop period: the interrupt priority mask in force at that moment and a clock-gating choice. While the subsystem is stopped, the block can drop a set of internal clock enables, depending on that stored choice. It also removes the enables of the bus, halt and spurious-interrupt monitors and pauses the software watchdog. The watchdog count is held, not cleared.

A set of interrupt request sources, each presenting a priority level, is compared against the stored mask. A level strictly greater than the mask ends the stop state. The block then passes through a single wake cycle, in which every enable is restored, before it returns to normal running. An active-low asynchronous reset ends the stop state at any time. The enable for the periodic interrupt timer is never removed, so that timer keeps counting through a stop.

The state machine has three states. RUN is normal operation. STOPPED is the low power state. WAKE is the single-cycle exit. There are five transitions:
- ENTER: RUN to STOPPED, on a stop command with no qualifying request.
- SHORTCUT: RUN to WAKE, on a stop command while a qualifying request is already present.
- RESUME: STOPPED to WAKE, on a qualifying request.
- RETURN: WAKE to RUN, always.
- ABORT: reset from any state to RUN.

Top module: `lpstop_ctrl`

## Requirements
- R1: After reset the block is in RUN. `in_stop` and `wake` are 0. Every bit of `clk_en`, `wdog_en` and the three monitor enables are 1.
- R2: A stop command in RUN with no qualifying request makes `in_stop` 1 from the next clock edge (ENTER). While `in_stop` is 1, `bus_mon_en`, `halt_mon_en`, `spur_mon_en` and `wdog_en` are 0. A watchdog counter driven by `wdog_en` keeps its value through the stop, is not cleared, and counts again from the first edge after the stop ends.
- R3: `cur_mask` is stored when a stop command is accepted. Changing `cur_mask` while stopped has no effect on wakeup.
- R4: `gate_clk` is stored when a stop command is accepted. If the stored value is 1, every bit of `clk_en` is 0 while stopped; if it is 0, every bit stays 1. Changing `gate_clk` while stopped has no effect.
- R5: Source i drives `req_lvl[i*LVL_W +: LVL_W]`, where source 0 is the periodic timer and source 1 is the external request. A level of 0 means no request. A stop ends (RESUME) on the edge after any source's level is strictly greater than the stored mask. A level equal to the mask does not wake, and this includes level 7 against mask 7.
- R6: WAKE lasts exactly one cycle. During it, `wake` is 1, `in_stop` is 0 and every enable is 1. On the next edge the block is in RUN, with `wake` 0 (RETURN).
- R7: A stop command in RUN while some level already exceeds `cur_mask` goes straight to WAKE (SHORTCUT), and `in_stop` never becomes 1.
- R8: Asserting `rst_n` low while stopped clears `in_stop` and restores every enable without waiting for a clock edge (ABORT).
- R9: A stop command has no effect while in STOPPED or WAKE.
- R10: `pit_en` is 1 in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stop_cmd | input | 1 | Stop command, sampled in RUN |
| cur_mask | input | LVL_W | Current interrupt priority mask |
| gate_clk | input | 1 | 1 = remove internal clock enables while stopped |
| req_lvl | input | NUM_SRC*LVL_W | Request level per source, 0 = none |
| clk_en | output | NUM_CLK_EN | Internal clock enables |
| wdog_en | output | 1 | Software watchdog count enable |
| bus_mon_en | output | 1 | Bus monitor enable |
| halt_mon_en | output | 1 | Halt monitor enable |
| spur_mon_en | output | 1 | Spurious interrupt monitor enable |
| pit_en | output | 1 | Periodic interrupt timer enable |
| in_stop | output | 1 | High in STOPPED |
| wake | output | 1 | High in WAKE |

## Verification
The bench builds the block with NUM_SRC=3 and NUM_CLK_EN=4, with LVL_W kept at 3. The extra third source confirms that the generated per-source comparators all take part in wakeup, not only the two named sources. The four-bit enable bus shows that gating acts on every bit together. With a 3-bit level, the top case of level 7 against mask 7 and the zero-level "no request" case can both be reached directly.

// File: rtl/lpstop_pkg.sv
package lpstop_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_STOPPED = 2'd1,
        ST_WAKE    = 2'd2
    } lp_state_t;

endpackage

// File: rtl/lpstop_wake_cmp.sv
module lpstop_wake_cmp #(
    parameter int NUM_SRC = 2,
    parameter int LVL_W   = 3
) (
    input  logic [NUM_SRC*LVL_W-1:0] req_lvl,
    input  logic [LVL_W-1:0]         mask,
    output logic                     hit
);

    logic [NUM_SRC-1:0] above;

    // One strict comparator per request source
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign above[g] = (req_lvl[g*LVL_W +: LVL_W] > mask);
    end

    assign hit = |above;

endmodule

// File: rtl/lpstop_capture.sv
module lpstop_capture #(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LVL_W-1:0] mask_in,
    input  logic             gate_in,
    output logic [LVL_W-1:0] mask_q,
    output logic             gate_q
);

    // Mask and gating choice are frozen from stop entry until next entry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            gate_q <= 1'b0;
        end else if (load) begin
            mask_q <= mask_in;
            gate_q <= gate_in;
        end
    end

endmodule

// File: rtl/lpstop_fsm.sv
module lpstop_fsm
    import lpstop_pkg::*;
#(
    parameter int NUM_CLK_EN = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stop_cmd,
    input  logic                  wake_hit,
    input  logic                  gate_q,
    output lp_state_t             state,
    output logic                  capture,
    output logic [NUM_CLK_EN-1:0] clk_en,
    output logic                  wdog_en,
    output logic                  mon_en,
    output logic                  in_stop,
    output logic                  wake
);

    localparam logic [NUM_CLK_EN-1:0] ALL_ON = {NUM_CLK_EN{1'b1}};

    lp_state_t nxt;

    // Next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (stop_cmd) nxt = wake_hit ? ST_WAKE : ST_STOPPED;
            end
            ST_STOPPED: begin
                if (wake_hit) nxt = ST_WAKE;
            end
            ST_WAKE: nxt = ST_RUN;
            default: nxt = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    assign capture = (state == ST_RUN) && stop_cmd;

    // Moore outputs
    always_comb begin
        clk_en  = ALL_ON;
        wdog_en = 1'b1;
        mon_en  = 1'b1;
        in_stop = 1'b0;
        wake    = 1'b0;
        unique case (state)
            ST_RUN: ;
            ST_STOPPED: begin
                clk_en  = gate_q ? '0 : ALL_ON;
                wdog_en = 1'b0;
                mon_en  = 1'b0;
                in_stop = 1'b1;
            end
            ST_WAKE: wake = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/lpstop_ctrl.sv
module lpstop_ctrl
    import lpstop_pkg::*;
#(
    parameter int NUM_SRC    = 2,
    parameter int LVL_W      = 3,
    parameter int NUM_CLK_EN = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stop_cmd,
    input  logic [LVL_W-1:0]         cur_mask,
    input  logic                     gate_clk,
    input  logic [NUM_SRC*LVL_W-1:0] req_lvl,
    output logic [NUM_CLK_EN-1:0]    clk_en,
    output logic                     wdog_en,
    output logic                     bus_mon_en,
    output logic                     halt_mon_en,
    output logic                     spur_mon_en,
    output logic                     pit_en,
    output logic                     in_stop,
    output logic                     wake
);

    lp_state_t        state;
    logic             capture;
    logic             gate_q;
    logic [LVL_W-1:0] mask_q;
    logic [LVL_W-1:0] cmp_mask;
    logic             wake_hit;
    logic             mon_en;

    // In RUN the live mask decides a shortcut; otherwise the stored one
    assign cmp_mask = (state == ST_RUN) ? cur_mask : mask_q;

    lpstop_wake_cmp #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_cmp (
        .req_lvl (req_lvl),
        .mask    (cmp_mask),
        .hit     (wake_hit)
    );

    lpstop_capture #(.LVL_W(LVL_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (capture),
        .mask_in (cur_mask),
        .gate_in (gate_clk),
        .mask_q  (mask_q),
        .gate_q  (gate_q)
    );

    lpstop_fsm #(.NUM_CLK_EN(NUM_CLK_EN)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop_cmd (stop_cmd),
        .wake_hit (wake_hit),
        .gate_q   (gate_q),
        .state    (state),
        .capture  (capture),
        .clk_en   (clk_en),
        .wdog_en  (wdog_en),
        .mon_en   (mon_en),
        .in_stop  (in_stop),
        .wake     (wake)
    );

    assign bus_mon_en  = mon_en;
    assign halt_mon_en = mon_en;
    assign spur_mon_en = mon_en;
    assign pit_en      = 1'b1;

endmodule

// File: rtl/lpstop_ctrl_chk.sv
module lpstop_ctrl_chk #(
    parameter int NUM_SRC    = 2,
    parameter int LVL_W      = 3,
    parameter int NUM_CLK_EN = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     stop_cmd,
    input logic [NUM_SRC*LVL_W-1:0] req_lvl,
    input logic [NUM_CLK_EN-1:0]    clk_en,
    input logic                     wdog_en,
    input logic                     bus_mon_en,
    input logic                     halt_mon_en,
    input logic                     spur_mon_en,
    input logic                     pit_en,
    input logic                     in_stop,
    input logic                     wake
);

    assert_mon_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_stop |-> (!bus_mon_en && !halt_mon_en && !spur_mon_en && !wdog_en));

    assert_stop_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_stop && !wake && stop_cmd && req_lvl == '0) |=> in_stop);

    assert_no_spurious_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stop && req_lvl == '0) |=> in_stop);

    assert_wake_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> (!wake && !in_stop));

    assert_wake_enables_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (&clk_en && wdog_en && bus_mon_en && !in_stop));

    assert_pit_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pit_en);

endmodule

bind lpstop_ctrl lpstop_ctrl_chk #(
    .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .NUM_CLK_EN(NUM_CLK_EN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .stop_cmd(stop_cmd), .req_lvl(req_lvl),
    .clk_en(clk_en), .wdog_en(wdog_en), .bus_mon_en(bus_mon_en),
    .halt_mon_en(halt_mon_en), .spur_mon_en(spur_mon_en), .pit_en(pit_en),
    .in_stop(in_stop), .wake(wake)
);

// File: tb/lpstop_ctrl_tb.sv
module lpstop_ctrl_tb;

    localparam int NS = 3;
    localparam int LW = 3;
    localparam int CE = 4;
    localparam logic [CE-1:0] ON = {CE{1'b1}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_cmd = 1'b0;
    logic [LW-1:0] cur_mask = '0;
    logic gate_clk = 1'b0;
    logic [NS*LW-1:0] req_lvl = '0;
    logic [CE-1:0] clk_en;
    logic wdog_en, bus_mon_en, halt_mon_en, spur_mon_en, pit_en, in_stop, wake;

    int n_tests = 0;
    int n_fail = 0;
    int wd_cnt = 0;

    always #5 clk = ~clk;

    lpstop_ctrl #(.NUM_SRC(NS), .LVL_W(LW), .NUM_CLK_EN(CE)) u_dut (
        .clk(clk), .rst_n(rst_n), .stop_cmd(stop_cmd), .cur_mask(cur_mask),
        .gate_clk(gate_clk), .req_lvl(req_lvl), .clk_en(clk_en),
        .wdog_en(wdog_en), .bus_mon_en(bus_mon_en), .halt_mon_en(halt_mon_en),
        .spur_mon_en(spur_mon_en), .pit_en(pit_en), .in_stop(in_stop),
        .wake(wake)
    );

    // Model of an external watchdog counter gated by wdog_en
    always @(posedge clk) if (wdog_en) wd_cnt <= wd_cnt + 1;

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_req(input int s0, input int s1, input int s2);
        req_lvl = {LW'(s2), LW'(s1), LW'(s0)};
    endtask

    task automatic stop_pulse(input int mask, input bit gate);
        @(negedge clk);
        cur_mask = LW'(mask);
        gate_clk = gate;
        stop_cmd = 1'b1;
        @(negedge clk);
        stop_cmd = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check("R1 in_stop", in_stop, 0);
        check("R1 wake", wake, 0);
        check("R1 clk_en", clk_en, ON);
        check("R1 enables", {wdog_en, bus_mon_en, halt_mon_en, spur_mon_en}, 4'hF);
        check("R10 pit_en run", pit_en, 1);
    endtask

    task automatic t_gated_stop();
        int w0;
        set_req(0, 0, 0);
        stop_pulse(3, 1'b1);
        check("R2 entered", in_stop, 1);
        check("R2 monitors off", {bus_mon_en, halt_mon_en, spur_mon_en}, 0);
        check("R2 wdog_en off", wdog_en, 0);
        check("R4 gated clk_en", clk_en, 0);
        check("R10 pit_en stop", pit_en, 1);
        w0 = wd_cnt;
        check("R2 wdog not cleared", (w0 > 0) ? 1 : 0, 1);
        // equal and lower levels, later mask/gate changes, extra stop cmd
        set_req(3, 2, 0);
        cur_mask = 3'd7;
        gate_clk = 1'b0;
        stop_cmd = 1'b1;
        repeat (3) @(negedge clk);
        stop_cmd = 1'b0;
        check("R5 equal level no wake", in_stop, 1);
        check("R9 stop cmd ignored", wake, 0);
        check("R4 gate latched", clk_en, 0);
        check("R2 wdog frozen", wd_cnt, w0);
        // external level 4 above stored mask 3 even though cur_mask is 7
        set_req(0, 4, 0);
        @(negedge clk);
        check("R3 stored mask wakes", wake, 1);
        check("R6 wake in_stop", in_stop, 0);
        check("R6 wake enables", {clk_en, wdog_en, bus_mon_en, halt_mon_en, spur_mon_en}, {ON, 4'hF});
        set_req(0, 0, 0);
        @(negedge clk);
        check("R6 one cycle wake", wake, 0);
        check("R6 back in run", in_stop, 0);
        check("R2 wdog resumed", wd_cnt, w0 + 1);
    endtask

    task automatic t_ungated_pit();
        set_req(0, 0, 0);
        stop_pulse(4, 1'b0);
        check("R4 ungated in_stop", in_stop, 1);
        check("R4 ungated clk_en", clk_en, ON);
        set_req(5, 0, 0);
        @(negedge clk);
        check("R5 periodic wake", wake, 1);
        set_req(0, 0, 0);
        @(negedge clk);
        check("R6 return", wake, 0);
    endtask

    task automatic t_level7_reset();
        set_req(0, 0, 0);
        stop_pulse(7, 1'b1);
        set_req(7, 7, 7);
        repeat (4) @(negedge clk);
        check("R5 level7 vs mask7", in_stop, 1);
        #2 rst_n = 1'b0;
        #1;
        check("R8 async exit", in_stop, 0);
        check("R8 clk_en restored", clk_en, ON);
        check("R8 monitors restored", {wdog_en, bus_mon_en}, 2'b11);
        set_req(0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_shortcut();
        @(negedge clk);
        set_req(0, 5, 0);
        cur_mask = 3'd2;
        stop_cmd = 1'b1;
        @(negedge clk);
        check("R7 shortcut wake", wake, 1);
        check("R7 never stopped", in_stop, 0);
        @(negedge clk);
        stop_cmd = 1'b0;
        check("R9 cmd in wake ignored", in_stop, 0);
        check("R9 wake ended", wake, 0);
        set_req(0, 0, 0);
    endtask

    task automatic t_third_src();
        set_req(0, 0, 0);
        stop_pulse(0, 1'b1);
        check("R5 src2 stopped", in_stop, 1);
        set_req(0, 0, 1);
        @(negedge clk);
        check("R5 third source wake", wake, 1);
        set_req(0, 0, 0);
        @(negedge clk);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_gated_stop();
                t_ungated_pit();
                t_level7_reset();
                t_shortcut();
                t_third_src();
            end
            begin
                repeat (5000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog expired actual=1 expected=0");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule